// File: doc/BRIEF.md
# Single-Channel DMA Transfer Controller

This block is the control half of one DMA channel. Software sets it up through a small memory-mapped register set: a control word, a source-address register and a transfer counter. The block then decides in which cycles a transfer happens. It raises a one-cycle transfer strobe for each transfer and exposes the current source address and the transfer size to an external bus master. After each strobe it steps the source address and decrements the counter. When the last transfer is done, it drops its own channel-enable bit.

Transfers happen only while both a master-enable bit and a channel-enable bit are set. In auto mode the channel issues a strobe on every clock while it is active. In requested mode it issues one strobe for each clock in which `req_i` is high. The channel-enable bit is protected against stray writes: software must read the control word while the bit is 0 before a write of 1 takes effect. A completion interrupt can be enabled. It stays asserted until software withdraws the interrupt enable or re-arms the channel.

Top module: `dma_chan_ctl`

## Requirements
- R1: `xfer_o` is high only while control bit 6 (master enable) and control bit 0 (channel enable) are both 1. When master enable is 0, the address and the count do not change.
- R2: Control bit 4 selects the mode. When it is 1 (auto), `xfer_o` is high on every active cycle. When it is 0 (requested), `xfer_o` follows `req_i` while the channel is active.
- R3: A write of 1 to control bit 0 sets it only when the last access to the control word before that write was a read that returned bit 0 = 0. A write of 1 without such a read leaves bit 0 at 0. A write of 0 always clears it.
- R4: The 16-bit counter at register offset 2 decrements on each strobe. The strobe that takes it from 1 to 0 also clears control bit 0 on the same edge.
- R5: While control bit 0 is 0, `req_i` produces no strobe and leaves the address and the count unchanged.
- R6: Completion sets a pending flag. `irq_o` is the pending flag ANDed with control bit 5 (interrupt enable). The flag is cleared by a control write with bit 5 = 0, or by a write that sets bit 0.
- R7: Control bit 2 enables address stepping and control bit 3 selects decrement (1) or increment (0). Control bit 1 selects word (1, step 2) or byte (0, step 1). The address at register offset 1 is updated on the strobe edge, modulo 2^16. With bit 2 at 0 the address stays fixed.
- R8: After reset the control word, the address, the count, `irq_o`, `xfer_o` and `size_word_o` are all 0.
- R9: A read (`sel_i` high, `wr_i` low) returns the selected register on `rdata_o` in the same cycle. Offset 0 is the control word (bits 15:7 read 0), offset 1 the address, offset 2 the count, and offset 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Register access strobe |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 2 | Register offset |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data |
| req_i | input | 1 | Transfer request in requested mode |
| xfer_o | output | 1 | One transfer this cycle |
| src_addr_o | output | 16 | Current source address |
| size_word_o | output | 1 | 1 = word transfer, 0 = byte transfer |
| irq_o | output | 1 | Completion interrupt |

## Verification
A wrong step size or direction shows up at `src_addr_o` right after the first strobe, so every stepping mode is run for several transfers from a known start address, including one that wraps. A counter that is off by one shows up as an extra or missing strobe, and as a channel-enable bit that clears one cycle too early or too late. The bench therefore reads the count and the control word back after a fixed window. A faulty arming guard would let a single blind write start the channel. The bench catches this by reading bit 0 back and by watching `xfer_o` stay low.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  typedef struct packed {
    logic master_en;
    logic irq_en;
    logic auto_req;
    logic step_dec;
    logic step_en;
    logic size_word;
    logic chan_en;
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_ADDR = 2'd1,
    REG_CNT  = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/dma_ctl_reg.sv
module dma_ctl_reg
  import dma_chan_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          done_i,
  output ctrl_t         ctrl_o,
  output logic          irq_o
);
  ctrl_t ctrl_q, ctrl_new;
  logic  armed_q, pend_q, rearm;

  always_comb begin
    ctrl_new = ctrl_t'(wdata_i[CTRL_W-1:0]);
    ctrl_new.chan_en = wdata_i[0] & (ctrl_q.chan_en | armed_q);
  end

  assign rearm = wr_i & ctrl_new.chan_en & ~ctrl_q.chan_en;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      armed_q <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      if (rd_i) armed_q <= ~ctrl_q.chan_en;
      if (wr_i) begin
        ctrl_q  <= ctrl_new;
        armed_q <= 1'b0;
      end
      if (done_i) ctrl_q.chan_en <= 1'b0;
      if (done_i) pend_q <= 1'b1;
      else if (rearm || (wr_i && !ctrl_new.irq_en)) pend_q <= 1'b0;
    end
  end

  assign ctrl_o = ctrl_q;
  assign irq_o  = pend_q & ctrl_q.irq_en;

  AST_ARM_NEEDS_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ctrl_q.chan_en) |-> $past(armed_q)); // R3
  AST_PEND_FROM_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pend_q) |-> $past(done_i)); // R6
endmodule

// File: rtl/dma_addr_step.sv
module dma_addr_step #(
  parameter int unsigned AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [AW-1:0] wdata_i,
  input  logic          xfer_i,
  input  logic          step_en_i,
  input  logic          step_dec_i,
  input  logic          size_word_i,
  output logic [AW-1:0] addr_o
);
  localparam logic [AW-1:0] STEP_B = AW'(1);
  localparam logic [AW-1:0] STEP_W = AW'(2);

  logic [AW-1:0] addr_q, step, stepped;

  assign step    = size_word_i ? STEP_W : STEP_B;
  assign stepped = step_dec_i ? addr_q - step : addr_q + step;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 addr_q <= '0;
    else if (wr_i)               addr_q <= wdata_i;
    else if (xfer_i && step_en_i) addr_q <= stepped;
  end

  assign addr_o = addr_q;

  AST_ADDR_FIXED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && !(xfer_i && step_en_i)) |=> $stable(addr_q)); // R7
endmodule

// File: rtl/dma_xfer_cnt.sv
module dma_xfer_cnt #(
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [CW-1:0] wdata_i,
  input  logic          xfer_i,
  output logic [CW-1:0] cnt_o,
  output logic          done_o
);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (wr_i)   cnt_q <= wdata_i;
    else if (xfer_i) cnt_q <= cnt_q - ONE;
  end

  assign cnt_o  = cnt_q;
  assign done_o = xfer_i & ~wr_i & (cnt_q == ONE);

  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_i && !wr_i) |=> cnt_q == $past(cnt_q) - ONE); // R4
endmodule

// File: rtl/dma_chan_ctl.sv
module dma_chan_ctl
  import dma_chan_pkg::*;
#(
  parameter int unsigned DW = 16,
  parameter int unsigned AW = 16,
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sel_i,
  input  logic          wr_i,
  input  logic [1:0]    addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic          req_i,
  output logic          xfer_o,
  output logic [AW-1:0] src_addr_o,
  output logic          size_word_o,
  output logic          irq_o
);
  ctrl_t         ctrl;
  logic          active, xfer, done;
  logic          wr_ctl, wr_addr, wr_cnt, rd_ctl;
  logic [AW-1:0] addr;
  logic [CW-1:0] cnt;

  assign wr_ctl  = sel_i & wr_i & (reg_sel_e'(addr_i) == REG_CTRL);
  assign wr_addr = sel_i & wr_i & (reg_sel_e'(addr_i) == REG_ADDR);
  assign wr_cnt  = sel_i & wr_i & (reg_sel_e'(addr_i) == REG_CNT);
  assign rd_ctl  = sel_i & ~wr_i & (reg_sel_e'(addr_i) == REG_CTRL);

  dma_ctl_reg #(.DW(DW)) u_ctl (
    .clk_i, .rst_ni, .rd_i(rd_ctl), .wr_i(wr_ctl), .wdata_i,
    .done_i(done), .ctrl_o(ctrl), .irq_o
  );

  assign active = ctrl.master_en & ctrl.chan_en;
  assign xfer   = active & (ctrl.auto_req | req_i);

  dma_addr_step #(.AW(AW)) u_addr (
    .clk_i, .rst_ni, .wr_i(wr_addr), .wdata_i(AW'(wdata_i)), .xfer_i(xfer),
    .step_en_i(ctrl.step_en), .step_dec_i(ctrl.step_dec),
    .size_word_i(ctrl.size_word), .addr_o(addr)
  );

  dma_xfer_cnt #(.CW(CW)) u_cnt (
    .clk_i, .rst_ni, .wr_i(wr_cnt), .wdata_i(CW'(wdata_i)), .xfer_i(xfer),
    .cnt_o(cnt), .done_o(done)
  );

  always_comb begin
    rdata_o = '0;
    if (sel_i && !wr_i) begin
      unique case (reg_sel_e'(addr_i))
        REG_CTRL: rdata_o = DW'(ctrl);
        REG_ADDR: rdata_o = DW'(addr);
        REG_CNT:  rdata_o = DW'(cnt);
        default:  rdata_o = '0;
      endcase
    end
  end

  assign xfer_o      = xfer;
  assign src_addr_o  = addr;
  assign size_word_o = ctrl.size_word;

  AST_IDLE_NO_XFER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl.chan_en |-> !xfer_o); // R5
  AST_LAST_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_o && cnt == CW'(1) && !wr_ctl && !wr_cnt) |=> !ctrl.chan_en); // R4
  AST_MASTER_GATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl.master_en && !wr_addr) |=> $stable(src_addr_o)); // R1
endmodule

// File: tb/dma_chan_ctl_tb_top.sv
module dma_chan_ctl_tb_top;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        sel = 1'b0, wr = 1'b0, req = 1'b0;
  logic [1:0]  addr = '0;
  logic [15:0] wdata = '0, rdata, src_addr;
  logic        xfer, size_word, irq;
  int          errors = 0, checks = 0;

  always #2 clk = ~clk;

  dma_chan_ctl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .wr_i(wr), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .req_i(req), .xfer_o(xfer),
    .src_addr_o(src_addr), .size_word_o(size_word), .irq_o(irq)
  );

  typedef struct packed {
    logic [2:0]  mode;   // {word, step_en, dec}
    logic [15:0] start;
    logic [15:0] exp;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{3'b000, 16'h1000, 16'h1000},
    '{3'b010, 16'h1000, 16'h1003},
    '{3'b011, 16'h1000, 16'h0FFD},
    '{3'b110, 16'h1000, 16'h1006},
    '{3'b111, 16'h1000, 16'h0FFA},
    '{3'b101, 16'h1000, 16'h1000},
    '{3'b011, 16'h0001, 16'hFFFE}
  };

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(logic [1:0] a, logic [15:0] d);
    @(negedge clk); sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); sel = 1'b0; wr = 1'b0;
  endtask

  task automatic bus_rd(logic [1:0] a, output logic [15:0] d);
    @(negedge clk); sel = 1'b1; wr = 1'b0; addr = a;
    #1 d = rdata;
    @(negedge clk); sel = 1'b0;
  endtask

  task automatic arm(logic [15:0] ctl);
    logic [15:0] tmp;
    bus_rd(2'd0, tmp);
    bus_wr(2'd0, ctl | 16'h0001);
  endtask

  task automatic pulse_req(output logic seen);
    @(negedge clk); req = 1'b1;
    #1 seen = xfer;
    @(negedge clk); req = 1'b0;
  endtask

  initial begin
    #(4 * 100000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] r;
    logic        s;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R8 reset state, R9 map
    bus_rd(2'd0, r); check("R8 ctrl", r, 0);
    bus_rd(2'd1, r); check("R8 addr", r, 0);
    bus_rd(2'd2, r); check("R8 cnt", r, 0);
    bus_rd(2'd3, r); check("R9 offset3", r, 0);
    check("R8 irq/xfer/size", {irq, xfer, size_word}, 0);

    // R7 stepping table, auto mode, three transfers each
    foreach (VECS[i]) begin
      bus_wr(2'd1, VECS[i].start);
      bus_wr(2'd2, 16'd3);
      arm(16'h0050 | {12'd0, VECS[i].mode[0], VECS[i].mode[1], VECS[i].mode[2], 1'b0});
      repeat (6) @(negedge clk);
      bus_rd(2'd1, r); check($sformatf("R7 addr vec%0d", i), r, VECS[i].exp);
      bus_rd(2'd2, r); check($sformatf("R4 cnt vec%0d", i), r, 0);
      bus_rd(2'd0, r); check($sformatf("R4 chan_en cleared vec%0d", i), r[0], 0);
    end

    // R3 blind write of 1 ignored (last access was a write)
    bus_wr(2'd0, 16'h0050);
    bus_wr(2'd0, 16'h0051);
    #1 check("R3 no strobe after blind write", xfer, 0);
    bus_rd(2'd0, r); check("R3 blind write", r, 16'h0050);
    bus_wr(2'd0, 16'h0000);

    // R1 master enable off gates the channel
    bus_wr(2'd1, 16'h2000);
    bus_wr(2'd2, 16'd2);
    arm(16'h0014);
    #1 check("R1 no xfer without master", xfer, 0);
    repeat (3) @(negedge clk);
    bus_rd(2'd1, r); check("R1 addr held", r, 16'h2000);
    bus_rd(2'd0, r); check("R1 chan_en kept", r, 16'h0015);
    bus_wr(2'd0, 16'h0055);
    repeat (4) @(negedge clk);
    bus_rd(2'd2, r); check("R2 auto ran to end", r, 0);
    bus_rd(2'd1, r); check("R7 byte inc x2", r, 16'h2002);

    // R5 requests ignored while disabled; R2 requested mode
    bus_wr(2'd1, 16'h3000);
    bus_wr(2'd2, 16'd2);
    bus_wr(2'd0, 16'h0044);
    pulse_req(s); check("R5 no strobe", s, 0);
    pulse_req(s); check("R5 no strobe 2", s, 0);
    bus_rd(2'd1, r); check("R5 addr unchanged", r, 16'h3000);
    bus_rd(2'd2, r); check("R5 cnt unchanged", r, 2);
    arm(16'h0064);
    #1 check("R2 idle without req", xfer, 0);
    pulse_req(s); check("R2 strobe on req", s, 1);
    bus_rd(2'd1, r); check("R7 step after req", r, 16'h3001);
    bus_rd(2'd2, r); check("R4 cnt after req", r, 1);
    check("R6 no irq before done", irq, 0);
    pulse_req(s); check("R2 second strobe", s, 1);
    #1 check("R6 irq on done", irq, 1);
    bus_rd(2'd0, r); check("R4 chan_en cleared", r, 16'h0064);
    bus_wr(2'd0, 16'h0044);
    #1 check("R6 irq cleared by irq_en=0", irq, 0);
    bus_wr(2'd0, 16'h0064);
    #1 check("R6 stays clear after re-enable", irq, 0);

    // R6 re-arm clears pending
    bus_wr(2'd2, 16'd1);
    arm(16'h0064);
    pulse_req(s);
    #1 check("R6 irq second done", irq, 1);
    bus_wr(2'd2, 16'd5);
    arm(16'h0064);
    #1 check("R6 irq cleared by re-arm", irq, 0);
    check("R7 size out byte", size_word, 0);
    bus_wr(2'd0, 16'h0002);
    #1 check("R7 size out word", size_word, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule